// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block holds the 32-bit status and control word of a floating-point unit. Software changes it through one operation port that carries a full-word write, a bitwise OR, AND or XOR update, or a command that clears only the fraction-inexact and fraction-rounded flags. The execution unit reports each finished operation on a second port. A report gives per-cause exception strobes, the result-class flags, and the fraction-inexact and fraction-rounded flags.

The cause and exception flags are sticky and only software clears them. The result-class flags and the two fraction flags are replaced by every report. Two summary bits are always derived again from the rest of the word: the invalid-operation summary and the enabled-exception summary. Any value software writes to them is lost. The overall exception summary is sticky. The block sets it when a report raises an exception bit that was clear, and software may clear it. One reserved bit never holds a one. The rounding mode, the flush-to-zero enable and the enabled-exception summary are also brought out as separate outputs.

Top module: `fpsc_reg`

## Requirements
- R1: A synchronous active-high reset clears the whole word, so `csr_q`, `round_mode`, `ftz_en` and `exc_enabled` all read 0.
- R2: Operation codes are 0 idle, 1 full write, 2 OR, 3 AND, 4 XOR, 5 clear fraction flags, and 6 and 7 idle. A full write loads `sw_data` into the word. `round_mode` is word bits 1..0 (0 nearest, 1 toward zero, 2 toward +inf, 3 toward -inf) and `ftz_en` is bit 2.
- R3: OR, AND and XOR combine `sw_data` with the current word, bit by bit, in the next cycle.
- R4: Bit 11 always reads 0, whatever the operation or data.
- R5: Bit 29 always equals the OR of the invalid-cause bits 8, 9, 10, 19, 20, 21, 22, 23 and 24.
- R6: Bit 30 and `exc_enabled` always equal (b29&b7)|(b28&b6)|(b27&b5)|(b26&b4)|(b25&b3).
- R7: When `ev_valid` is high, each `ev_inv[i]` ORs into cause bit 8,9,10,19,20,21,22,23,24 for i=0..8, and each `ev_exc[j]` ORs into bit 25,26,27,28 for j=0..3. Bits 16..12 take `ev_class`, bit 17 takes `ev_fi` and bit 18 takes `ev_fr`.
- R8: A report that sets a cause or exception bit which was clear also sets bit 31. Software can write bit 31 to 0.
- R9: Operation 5 zeroes bits 17 and 18 and leaves every other stored bit as it was.
- R10: When a software operation and a report arrive in the same cycle, the software operation is applied first and the report is merged on top. "Was clear" in R8 refers to the word after the software operation.
- R11: With the idle operation, no sticky bit (8..10, 19..28, 31) ever goes from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_op | input | 3 | Software operation code |
| sw_data | input | 32 | Software operand |
| ev_valid | input | 1 | Execution-unit report strobe |
| ev_inv | input | 9 | Invalid-operation cause strobes |
| ev_exc | input | 4 | Inexact, zero-divide, underflow, overflow strobes |
| ev_class | input | 5 | Result-class and compare flags |
| ev_fi | input | 1 | Fraction inexact |
| ev_fr | input | 1 | Fraction rounded |
| csr_q | output | 32 | Register value |
| round_mode | output | 2 | Rounding mode |
| ftz_en | output | 1 | Flush-to-zero enable |
| exc_enabled | output | 1 | Enabled-exception summary |

## Verification
The sticky-hold and exception-summary assertions assume that the operation code is a known value on every clock. They also assume that a software operation in the same cycle may legitimately clear sticky bits, so both properties are qualified on the idle code. The random stimulus always drives defined values on every input. It draws operation codes across all eight encodings, including the two unused ones. It keeps cause strobes sparse so that the set-on-new-exception case and the already-set case both occur often.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;
  localparam int WORD_W   = 32;
  localparam int N_INV    = 9;
  localparam int N_EXC    = 4;
  localparam int CLASS_W  = 5;
  localparam int OP_W     = 3;

  localparam int RSV_BIT  = 11;
  localparam int CLASS_LO = 12;
  localparam int FI_BIT   = 17;
  localparam int FR_BIT   = 18;
  localparam int VX_BIT   = 29;
  localparam int FEX_BIT  = 30;
  localparam int FX_BIT   = 31;

  // cause bit positions, indexed by strobe number
  localparam int INV_POS [N_INV] = '{8, 9, 10, 19, 20, 21, 22, 23, 24};
  // exception flags: inexact, zero-divide, underflow, overflow
  localparam int EXC_POS [N_EXC] = '{25, 26, 27, 28};
  // matching enable bits
  localparam int EN_POS  [N_EXC] = '{3, 4, 5, 6};
  localparam int VE_BIT  = 7;

  typedef enum logic [OP_W-1:0] {
    OP_IDLE  = 3'd0,
    OP_WRITE = 3'd1,
    OP_OR    = 3'd2,
    OP_AND   = 3'd3,
    OP_XOR   = 3'd4,
    OP_CLRF  = 3'd5
  } fpsc_op_e;
endpackage

// File: rtl/fpsc_sw_update.sv
module fpsc_sw_update
  import fpsc_pkg::*;
(
  input  logic [WORD_W-1:0] cur,
  input  logic [OP_W-1:0]   op,
  input  logic [WORD_W-1:0] data,
  output logic [WORD_W-1:0] nxt
);
  always_comb begin
    nxt = cur;
    case (op)
      OP_WRITE: nxt = data;
      OP_OR:    nxt = cur | data;
      OP_AND:   nxt = cur & data;
      OP_XOR:   nxt = cur ^ data;
      OP_CLRF: begin
        nxt[FI_BIT] = 1'b0;
        nxt[FR_BIT] = 1'b0;
      end
      default:  nxt = cur;
    endcase
    nxt[RSV_BIT] = 1'b0;
  end
endmodule

// File: rtl/fpsc_event_merge.sv
module fpsc_event_merge
  import fpsc_pkg::*;
(
  input  logic [WORD_W-1:0]  base,
  input  logic               valid,
  input  logic [N_INV-1:0]   inv,
  input  logic [N_EXC-1:0]   exc,
  input  logic [CLASS_W-1:0] cls,
  input  logic               fi,
  input  logic               fr,
  output logic [WORD_W-1:0]  merged
);
  logic [WORD_W-1:0] raise;

  for (genvar i = 0; i < N_INV; i++) begin : g_inv
    assign raise[INV_POS[i]] = inv[i];
  end
  for (genvar j = 0; j < N_EXC; j++) begin : g_exc
    assign raise[EXC_POS[j]] = exc[j];
  end
  assign raise[7:0]              = '0;
  assign raise[CLASS_LO+6:RSV_BIT] = '0;
  assign raise[WORD_W-1:VX_BIT]  = '0;

  always_comb begin
    merged = base;
    if (valid) begin
      if (|(raise & ~base)) merged[FX_BIT] = 1'b1;
      merged = merged | raise;
      merged[CLASS_LO +: CLASS_W] = cls;
      merged[FI_BIT] = fi;
      merged[FR_BIT] = fr;
    end
  end
endmodule

// File: rtl/fpsc_summary.sv
module fpsc_summary
  import fpsc_pkg::*;
(
  input  logic [WORD_W-1:0] pre,
  output logic [WORD_W-1:0] post
);
  logic [N_INV-1:0] inv_bits;
  logic [N_EXC-1:0] hit;

  for (genvar i = 0; i < N_INV; i++) begin : g_inv
    assign inv_bits[i] = pre[INV_POS[i]];
  end
  for (genvar j = 0; j < N_EXC; j++) begin : g_hit
    assign hit[j] = pre[EXC_POS[j]] & pre[EN_POS[j]];
  end

  always_comb begin
    post = pre;
    post[VX_BIT]  = |inv_bits;
    post[FEX_BIT] = (post[VX_BIT] & pre[VE_BIT]) | (|hit);
  end
endmodule

// File: rtl/fpsc_reg.sv
module fpsc_reg
  import fpsc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [OP_W-1:0]    sw_op,
  input  logic [WORD_W-1:0]  sw_data,
  input  logic               ev_valid,
  input  logic [N_INV-1:0]   ev_inv,
  input  logic [N_EXC-1:0]   ev_exc,
  input  logic [CLASS_W-1:0] ev_class,
  input  logic               ev_fi,
  input  logic               ev_fr,
  output logic [WORD_W-1:0]  csr_q,
  output logic [1:0]         round_mode,
  output logic               ftz_en,
  output logic               exc_enabled
);
  logic [WORD_W-1:0] word_r, after_sw, after_ev, word_d;

  fpsc_sw_update u_sw (
    .cur (word_r),
    .op  (sw_op),
    .data(sw_data),
    .nxt (after_sw)
  );

  fpsc_event_merge u_ev (
    .base  (after_sw),
    .valid (ev_valid),
    .inv   (ev_inv),
    .exc   (ev_exc),
    .cls   (ev_class),
    .fi    (ev_fi),
    .fr    (ev_fr),
    .merged(after_ev)
  );

  fpsc_summary u_sum (
    .pre (after_ev),
    .post(word_d)
  );

  always_ff @(posedge clk) begin
    if (rst) word_r <= '0;
    else     word_r <= word_d;
  end

  assign csr_q       = word_r;
  assign round_mode  = word_r[1:0];
  assign ftz_en      = word_r[2];
  assign exc_enabled = word_r[FEX_BIT];
endmodule

// File: rtl/fpsc_chk.sv
module fpsc_chk
  import fpsc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [OP_W-1:0]   sw_op,
  input logic              ev_valid,
  input logic [N_INV-1:0]  ev_inv,
  input logic [N_EXC-1:0]  ev_exc,
  input logic [WORD_W-1:0] csr_q,
  input logic              exc_enabled
);
  localparam logic [WORD_W-1:0] STICKY = 32'h9FF8_0700;

  logic [N_INV-1:0] q_inv;
  logic [N_EXC-1:0] q_exc;
  for (genvar i = 0; i < N_INV; i++) begin : g_qi
    assign q_inv[i] = csr_q[INV_POS[i]];
  end
  for (genvar j = 0; j < N_EXC; j++) begin : g_qe
    assign q_exc[j] = csr_q[EXC_POS[j]];
  end

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> csr_q == '0);

  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    !csr_q[RSV_BIT]);

  a_r5_vx_summary: assert property (@(posedge clk) disable iff (rst)
    csr_q[VX_BIT] == (|q_inv));

  a_r6_fex_summary: assert property (@(posedge clk) disable iff (rst)
    exc_enabled == ((csr_q[VX_BIT] & csr_q[7]) | (csr_q[28] & csr_q[6]) |
                    (csr_q[27] & csr_q[5]) | (csr_q[26] & csr_q[4]) |
                    (csr_q[25] & csr_q[3])));

  a_r8_fx_on_new: assert property (@(posedge clk) disable iff (rst)
    (sw_op == OP_IDLE && ev_valid && ((|(ev_inv & ~q_inv)) || (|(ev_exc & ~q_exc))))
    |=> csr_q[FX_BIT]);

  a_r9_clear_fraction: assert property (@(posedge clk) disable iff (rst)
    (sw_op == OP_CLRF && !ev_valid) |=> (csr_q[FR_BIT:FI_BIT] == 2'b00));

  a_r11_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    (sw_op == OP_IDLE) |=> ((csr_q & $past(csr_q) & STICKY) == ($past(csr_q) & STICKY)));
endmodule

bind fpsc_reg fpsc_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .sw_op      (sw_op),
  .ev_valid   (ev_valid),
  .ev_inv     (ev_inv),
  .ev_exc     (ev_exc),
  .csr_q      (csr_q),
  .exc_enabled(exc_enabled)
);

// File: tb/fpsc_reg_tb.sv
module fpsc_reg_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  sw_op = '0;
  logic [31:0] sw_data = '0;
  logic        ev_valid = 1'b0;
  logic [8:0]  ev_inv = '0;
  logic [3:0]  ev_exc = '0;
  logic [4:0]  ev_class = '0;
  logic        ev_fi = 1'b0, ev_fr = 1'b0;
  logic [31:0] csr_q;
  logic [1:0]  round_mode;
  logic        ftz_en, exc_enabled;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] exp_q = '0;

  always #4 clk = ~clk;

  fpsc_reg u_dut (
    .clk(clk), .rst(rst), .sw_op(sw_op), .sw_data(sw_data),
    .ev_valid(ev_valid), .ev_inv(ev_inv), .ev_exc(ev_exc),
    .ev_class(ev_class), .ev_fi(ev_fi), .ev_fr(ev_fr),
    .csr_q(csr_q), .round_mode(round_mode), .ftz_en(ftz_en),
    .exc_enabled(exc_enabled)
  );

  function automatic logic [31:0] model(input logic [31:0] q, input logic [2:0] op,
      input logic [31:0] d, input logic v, input logic [8:0] inv, input logic [3:0] exc,
      input logic [4:0] cls, input logic fi, input logic fr);
    logic [31:0] b, nb;
    logic vx;
    b = q;
    case (op)
      3'd1: b = d;
      3'd2: b = q | d;
      3'd3: b = q & d;
      3'd4: b = q ^ d;
      3'd5: begin b[17] = 1'b0; b[18] = 1'b0; end
      default: b = q;
    endcase
    b[11] = 1'b0;
    if (v) begin
      nb = '0;
      nb[10:8] = inv[2:0];
      nb[24:19] = inv[8:3];
      nb[28:25] = exc;
      if ((nb & ~b) != 0) b[31] = 1'b1;
      b = b | nb;
      b[16:12] = cls;
      b[17] = fi;
      b[18] = fr;
    end
    vx = |{b[24:19], b[10:8]};
    b[29] = vx;
    b[30] = (vx & b[7]) | (b[28] & b[6]) | (b[27] & b[5]) | (b[26] & b[4]) | (b[25] & b[3]);
    return b;
  endfunction

  task automatic check(input string req);
    n_chk++;
    if (csr_q !== exp_q || round_mode !== exp_q[1:0] || ftz_en !== exp_q[2] ||
        exc_enabled !== exp_q[30]) begin
      n_fail++;
      $display("FAIL %s: csr_q=%h rm=%0d ftz=%b fex=%b expected csr_q=%h", req,
               csr_q, round_mode, ftz_en, exc_enabled, exp_q);
    end
  endtask

  // drive one cycle at the falling edge, check at the next falling edge
  task automatic step(input logic [2:0] op, input logic [31:0] d, input logic v,
      input logic [8:0] inv, input logic [3:0] exc, input logic [4:0] cls,
      input logic fi, input logic fr, input string req);
    sw_op = op; sw_data = d; ev_valid = v; ev_inv = inv; ev_exc = exc;
    ev_class = cls; ev_fi = fi; ev_fr = fr;
    exp_q = model(exp_q, op, d, v, inv, exc, cls, fi, fr);
    @(negedge clk);
    check(req);
  endtask

  task automatic idle(input string req);
    step(3'd0, '0, 1'b0, '0, '0, '0, 1'b0, 1'b0, req);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_q = '0;
    check("R1 reset");
    // R2 full write, everything set; R4 bit 11 masked, R5/R6 derived
    step(3'd1, 32'hFFFF_FFFF, 1'b0, '0, '0, '0, 1'b0, 1'b0, "R2 R4 write ones");
    // R2 writing only summaries: recomputed to 0
    step(3'd1, 32'h6000_0000, 1'b0, '0, '0, '0, 1'b0, 1'b0, "R5 R6 summaries overwritten");
    step(3'd1, 32'h0000_0806, 1'b0, '0, '0, '0, 1'b0, 1'b0, "R2 R4 rounding and ftz");
    step(3'd2, 32'h0000_0811, 1'b0, '0, '0, '0, 1'b0, 1'b0, "R3 R4 or update");
    step(3'd3, 32'hFFFF_FFFD, 1'b0, '0, '0, '0, 1'b0, 1'b0, "R3 and update");
    step(3'd4, 32'h0000_0803, 1'b0, '0, '0, '0, 1'b0, 1'b0, "R3 R4 xor update");
    // zero-divide enabled (bit 4 set): event raises ZX -> FEX, FX
    step(3'd0, '0, 1'b1, '0, 4'b0010, 5'h1F, 1'b1, 1'b1, "R6 R7 R8 zero-divide event");
    idle("R11 sticky hold");
    // same flag again: FX already set; clear FX by write keeps ZX?
    step(3'd1, 32'h0400_0010, 1'b0, '0, '0, '0, 1'b0, 1'b0, "R8 software clears FX");
    step(3'd0, '0, 1'b1, '0, 4'b0010, 5'h02, 1'b1, 1'b0, "R8 already-set flag no FX");
    step(3'd0, '0, 1'b1, 9'h100, '0, 5'h03, 1'b1, 1'b1, "R5 R7 R8 snan cause");
    step(3'd5, '0, 1'b0, '0, '0, '0, 1'b0, 1'b0, "R9 clear fraction flags");
    step(3'd0, '0, 1'b0, '0, '0, '0, 1'b0, 1'b0, "R11 idle keeps");
    step(3'd1, 32'h0000_0080, 1'b1, '0, 4'b1000, 5'h04, 1'b0, 1'b1, "R10 write then overflow event");
    step(3'd6, 32'hFFFF_FFFF, 1'b0, '0, '0, '0, 1'b0, 1'b0, "R2 unused code idle");
    step(3'd1, 32'h0000_0080, 1'b1, 9'h001, '0, 5'h00, 1'b0, 1'b0, "R10 R5 R6 write then invalid cause");
    for (int k = 0; k < 3000; k++) begin
      logic [2:0] op;
      logic [31:0] d;
      string tag;
      op = (($urandom % 3) == 0) ? 3'd0 : 3'($urandom);
      d = $urandom;
      case (op)
        3'd1: tag = "R2 random write";
        3'd2, 3'd3, 3'd4: tag = "R3 random update";
        3'd5: tag = "R9 random clear";
        default: tag = "R7 R11 random idle";
      endcase
      step(op, d, 1'($urandom), 9'($urandom & $urandom & $urandom),
           4'($urandom & $urandom), 5'($urandom), 1'($urandom), 1'($urandom), tag);
    end
    rst = 1'b1;
    exp_q = '0;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset again");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule